// File: doc/BRIEF.md
# Host Parallel Mailbox Port

This block gives an external host a window of eight 8-bit registers through a passive parallel port. The host drives a 3-bit register select, an active-low chip select, an active-low read strobe and an active-low write strobe. The local processor reaches the same eight registers over a simple single-cycle internal bus. The port never starts a transfer. It only answers the host.

The register window works as a two-way mailbox. The host owns registers 4 to 7 and the processor owns registers 0 to 3, so each side writes only its own half. Either side can read all eight registers. Register 0 is the control word: bits 1:0 hold the interrupt enables and bits 5:4 show the pending flags. When the host-side enable is set, a processor write to register 3 pulls the host interrupt line low, and a host read of register 3 releases it. When the processor-side enable is set, a host write to register 7 raises the processor interrupt, and a processor read of register 7 clears it.

The host strobes pass through a two-stage synchronizer before a five-state handshake machine acts on them:

- ST_IDLE waits for a strobe. It goes to ST_WR_HOLD when chip select and write are both active. Otherwise it goes to ST_RD_OPEN when chip select and read are both active.
- ST_WR_HOLD stays put while the write strobe pair is held. It goes to ST_WR_COMMIT when the pair is released.
- ST_WR_COMMIT lasts one cycle, applies the write, and returns to ST_IDLE.
- ST_RD_OPEN lasts one cycle and marks the start of a read. It goes to ST_RD_HOLD if the read strobe pair is still active, or back to ST_IDLE if it is not.
- ST_RD_HOLD goes back to ST_IDLE when the read strobe pair is released.

Select and data are sampled on every clock except in ST_WR_COMMIT. The host must therefore hold them stable for three clock periods after it releases the write strobe.

Top module: `hpm_mailbox`

## Requirements
- R1: After reset, all eight registers read 0, `h_irq_n` is 1, `p_irq` is 0 and `h_data_oe` is 0.
- R2: A processor write to registers 1 to 3 stores the data. A processor write to register 0 keeps only bits 1:0. Processor writes to registers 4 to 7 are ignored. `p_rdata` shows register `p_addr` in the same cycle.
- R3: A host write to registers 4 to 7 stores the data when the write strobe pair ends. The new value is visible on `p_rdata` no later than five clocks after the strobe ends.
- R4: Host writes to registers 0 to 3 are ignored.
- R5: `h_data_oe` is 1 exactly while `h_cs_n` and `h_rd_n` are both 0. `h_data_out` shows register `h_sel`.
- R6: With enable bit 0 set, a processor write to register 3 drives `h_irq_n` to 0 on the next clock. A host read of register 3 returns it to 1.
- R7: With enable bit 1 set, a host write to register 7 sets `p_irq`. A processor read of register 7 clears `p_irq` on the next clock.
- R8: With an enable bit at 0, the matching interrupt is never raised. Clearing an enable bit also drops a pending interrupt of that kind.
- R9: Register 0 reads back bit 4 as the pending host interrupt and bit 5 as the pending processor interrupt.
- R10: A write strobe given while `h_cs_n` is 1 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset |
| h_sel | input | 3 | Host register select |
| h_cs_n | input | 1 | Host chip select, active low |
| h_rd_n | input | 1 | Host read strobe, active low |
| h_wr_n | input | 1 | Host write strobe, active low |
| h_data_in | input | 8 | Host write data |
| h_data_out | output | 8 | Host read data |
| h_data_oe | output | 1 | Host data bus drive enable |
| h_irq_n | output | 1 | Interrupt to host, active low |
| p_addr | input | 3 | Processor register address |
| p_wr | input | 1 | Processor write strobe |
| p_rd | input | 1 | Processor read strobe |
| p_wdata | input | 8 | Processor write data |
| p_rdata | output | 8 | Processor read data |
| p_irq | output | 1 | Interrupt to processor |

## Verification
The hardest case to reach is an enable being cleared in the same stretch in which its interrupt is pending. The bench reaches it by enabling both interrupts first. It then raises the processor interrupt with a full host write to register 7 and, while that interrupt is still outstanding, rewrites the control word with bit 1 cleared. At that point `p_irq` must fall and bit 5 of the control readback must be 0. A second hard case is the release of the host interrupt, which depends on a read strobe passing through the synchronizer and the one-cycle ST_RD_OPEN state. To reach it, the bench holds each host strobe for several clocks and samples `h_irq_n` only after the release.

// File: rtl/hpm_pkg.sv
package hpm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WR_HOLD   = 3'd1,
        ST_WR_COMMIT = 3'd2,
        ST_RD_OPEN   = 3'd3,
        ST_RD_HOLD   = 3'd4
    } hs_state_e;

    // register indices that carry behaviour
    localparam int unsigned REG_CTRL      = 0;
    localparam int unsigned REG_TO_HOST   = 3;
    localparam int unsigned REG_TO_PROC   = 7;

    // control word bit positions
    localparam int unsigned CTL_EN_HOST   = 0;
    localparam int unsigned CTL_EN_PROC   = 1;
    localparam int unsigned CTL_FLG_HOST  = 4;
    localparam int unsigned CTL_FLG_PROC  = 5;

endpackage

// File: rtl/hpm_sync.sv
module hpm_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[0] <= RST_VAL;
                    else        stage[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[g] <= RST_VAL;
                    else        stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/hpm_host_fsm.sv
module hpm_host_fsm
    import hpm_pkg::*;
#(
    parameter int unsigned AW = 3,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_act,
    input  logic          rd_act,
    input  logic          wr_act,
    input  logic [AW-1:0] h_sel,
    input  logic [DW-1:0] h_din,
    output logic          wr_commit,
    output logic          rd_open,
    output logic [AW-1:0] cap_sel,
    output logic [DW-1:0] cap_data
);
    hs_state_e state_q, state_d;
    logic      wr_go, rd_go;

    assign wr_go = cs_act && wr_act;
    assign rd_go = cs_act && rd_act;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_go)      state_d = ST_WR_HOLD;
                else if (rd_go) state_d = ST_RD_OPEN;
            end
            ST_WR_HOLD:   if (!wr_go) state_d = ST_WR_COMMIT;
            ST_WR_COMMIT: state_d = ST_IDLE;
            ST_RD_OPEN:   state_d = rd_go ? ST_RD_HOLD : ST_IDLE;
            ST_RD_HOLD:   if (!rd_go) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_commit = 1'b0;
        rd_open   = 1'b0;
        unique case (state_q)
            ST_WR_COMMIT: wr_commit = 1'b1;
            ST_RD_OPEN:   rd_open   = 1'b1;
            default: ;
        endcase
    end

    // select/data capture, frozen during the commit cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_sel  <= '0;
            cap_data <= '0;
        end else if (state_q != ST_WR_COMMIT) begin
            cap_sel  <= h_sel;
            cap_data <= h_din;
        end
    end

    assert_commit_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);
    assert_read_open_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_open |=> !rd_open);
    assert_commit_needs_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && state_q == ST_WR_HOLD) |=> !wr_commit);
endmodule

// File: rtl/hpm_regfile.sv
module hpm_regfile
    import hpm_pkg::*;
#(
    parameter int unsigned AW = 3,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          p_wr,
    input  logic          p_rd,
    input  logic [AW-1:0] p_addr,
    input  logic [DW-1:0] p_wdata,
    output logic [DW-1:0] p_rdata,
    input  logic          h_commit,
    input  logic [AW-1:0] h_wsel,
    input  logic [DW-1:0] h_wdata,
    input  logic          h_open,
    input  logic [AW-1:0] h_rsel,
    input  logic [AW-1:0] h_sel,
    output logic [DW-1:0] h_rdata,
    output logic          host_flag,
    output logic          proc_flag
);
    localparam int unsigned NREG = 1 << AW;
    localparam int unsigned HALF = NREG / 2;
    localparam logic [DW-1:0] CTRL_MASK =
        DW'((1 << CTL_EN_HOST) | (1 << CTL_EN_PROC));

    logic [DW-1:0] mem [NREG];
    logic [DW-1:0] ctrl_view;
    logic          ctrl_wr, en_host_nx, en_proc_nx;
    logic          host_set, host_clr, proc_set, proc_clr;

    genvar i;
    generate
        for (i = 0; i < NREG; i++) begin : g_reg
            if (i == REG_CTRL) begin : g_ctrl
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) mem[i] <= '0;
                    else if (p_wr && p_addr == AW'(i)) mem[i] <= p_wdata & CTRL_MASK;
                end
            end else if (i < HALF) begin : g_proc_owned
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) mem[i] <= '0;
                    else if (p_wr && p_addr == AW'(i)) mem[i] <= p_wdata;
                end
            end else begin : g_host_owned
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) mem[i] <= '0;
                    else if (h_commit && h_wsel == AW'(i)) mem[i] <= h_wdata;
                end
            end
        end
    endgenerate

    assign ctrl_wr    = p_wr && (p_addr == AW'(REG_CTRL));
    assign en_host_nx = ctrl_wr ? p_wdata[CTL_EN_HOST] : mem[REG_CTRL][CTL_EN_HOST];
    assign en_proc_nx = ctrl_wr ? p_wdata[CTL_EN_PROC] : mem[REG_CTRL][CTL_EN_PROC];

    assign host_set = p_wr && (p_addr == AW'(REG_TO_HOST)) && en_host_nx;
    assign host_clr = h_open && (h_rsel == AW'(REG_TO_HOST));
    assign proc_set = h_commit && (h_wsel == AW'(REG_TO_PROC)) && en_proc_nx;
    assign proc_clr = p_rd && (p_addr == AW'(REG_TO_PROC));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_flag <= 1'b0;
            proc_flag <= 1'b0;
        end else begin
            if (!en_host_nx)   host_flag <= 1'b0;
            else if (host_set) host_flag <= 1'b1;
            else if (host_clr) host_flag <= 1'b0;

            if (!en_proc_nx)   proc_flag <= 1'b0;
            else if (proc_set) proc_flag <= 1'b1;
            else if (proc_clr) proc_flag <= 1'b0;
        end
    end

    always_comb begin
        ctrl_view = mem[REG_CTRL];
        ctrl_view[CTL_FLG_HOST] = host_flag;
        ctrl_view[CTL_FLG_PROC] = proc_flag;
    end

    assign p_rdata = (p_addr == AW'(REG_CTRL)) ? ctrl_view : mem[p_addr];
    assign h_rdata = (h_sel  == AW'(REG_CTRL)) ? ctrl_view : mem[h_sel];

    assert_host_irq_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (p_wr && p_addr == AW'(REG_TO_HOST) && mem[REG_CTRL][CTL_EN_HOST]) |=> host_flag);
    assert_host_irq_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_clr && !host_set) |=> !host_flag);
    assert_proc_irq_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_clr && !proc_set) |=> !proc_flag);
    assert_disabled_host_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem[REG_CTRL][CTL_EN_HOST] |-> !host_flag);
    assert_disabled_proc_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem[REG_CTRL][CTL_EN_PROC] |-> !proc_flag);
    assert_host_ro_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (h_commit && !h_wsel[AW-1] && !p_wr) |=>
        ($stable(mem[0]) && $stable(mem[1]) && $stable(mem[HALF-1])));
    assert_proc_ro_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (p_wr && p_addr[AW-1] && !h_commit) |=>
        ($stable(mem[HALF]) && $stable(mem[NREG-1])));
endmodule

// File: rtl/hpm_mailbox.sv
module hpm_mailbox
    import hpm_pkg::*;
#(
    parameter int unsigned AW          = 3,
    parameter int unsigned DW          = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] h_sel,
    input  logic          h_cs_n,
    input  logic          h_rd_n,
    input  logic          h_wr_n,
    input  logic [DW-1:0] h_data_in,
    output logic [DW-1:0] h_data_out,
    output logic          h_data_oe,
    output logic          h_irq_n,
    input  logic [AW-1:0] p_addr,
    input  logic          p_wr,
    input  logic          p_rd,
    input  logic [DW-1:0] p_wdata,
    output logic [DW-1:0] p_rdata,
    output logic          p_irq
);
    logic [2:0]    strobe_q;
    logic          wr_commit, rd_open, host_flag, proc_flag;
    logic [AW-1:0] cap_sel;
    logic [DW-1:0] cap_data;

    hpm_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({h_cs_n, h_rd_n, h_wr_n}),
        .q     (strobe_q)
    );

    hpm_host_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (!strobe_q[2]),
        .rd_act    (!strobe_q[1]),
        .wr_act    (!strobe_q[0]),
        .h_sel     (h_sel),
        .h_din     (h_data_in),
        .wr_commit (wr_commit),
        .rd_open   (rd_open),
        .cap_sel   (cap_sel),
        .cap_data  (cap_data)
    );

    hpm_regfile #(.AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .p_wr      (p_wr),
        .p_rd      (p_rd),
        .p_addr    (p_addr),
        .p_wdata   (p_wdata),
        .p_rdata   (p_rdata),
        .h_commit  (wr_commit),
        .h_wsel    (cap_sel),
        .h_wdata   (cap_data),
        .h_open    (rd_open),
        .h_rsel    (cap_sel),
        .h_sel     (h_sel),
        .h_rdata   (h_data_out),
        .host_flag (host_flag),
        .proc_flag (proc_flag)
    );

    assign h_data_oe = !h_cs_n && !h_rd_n;
    assign h_irq_n   = !host_flag;
    assign p_irq     = proc_flag;

    assert_irq_low_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(h_irq_n) |-> $past(p_wr) && ($past(p_addr) == AW'(REG_TO_HOST)));
endmodule

// File: tb/hpm_mailbox_test.sv
module hpm_mailbox_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] h_sel = '0;
    logic       h_cs_n = 1'b1, h_rd_n = 1'b1, h_wr_n = 1'b1;
    logic [7:0] h_data_in = '0;
    logic [7:0] h_data_out;
    logic       h_data_oe, h_irq_n;
    logic [2:0] p_addr = '0;
    logic       p_wr = 1'b0, p_rd = 1'b0;
    logic [7:0] p_wdata = '0;
    logic [7:0] p_rdata;
    logic       p_irq;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    hpm_mailbox uut (
        .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_cs_n(h_cs_n), .h_rd_n(h_rd_n),
        .h_wr_n(h_wr_n), .h_data_in(h_data_in), .h_data_out(h_data_out),
        .h_data_oe(h_data_oe), .h_irq_n(h_irq_n), .p_addr(p_addr), .p_wr(p_wr),
        .p_rd(p_rd), .p_wdata(p_wdata), .p_rdata(p_rdata), .p_irq(p_irq)
    );

    // op codes: 0 processor write, 1 host write, 2 processor check, 3 host check
    localparam int NV = 17;
    localparam logic [20:0] VEC [NV] = '{
        {2'd0, 3'd2, 8'hA5, 8'h00},
        {2'd0, 3'd3, 8'h3C, 8'h00},
        {2'd0, 3'd1, 8'h11, 8'h00},
        {2'd1, 3'd5, 8'h5A, 8'h00},
        {2'd1, 3'd6, 8'hC3, 8'h00},
        {2'd1, 3'd4, 8'h99, 8'h00},
        {2'd1, 3'd1, 8'hEE, 8'h00},
        {2'd0, 3'd4, 8'h77, 8'h00},
        {2'd2, 3'd2, 8'h00, 8'hA5},
        {2'd2, 3'd3, 8'h00, 8'h3C},
        {2'd2, 3'd1, 8'h00, 8'h11},
        {2'd2, 3'd5, 8'h00, 8'h5A},
        {2'd2, 3'd6, 8'h00, 8'hC3},
        {2'd2, 3'd4, 8'h00, 8'h99},
        {2'd3, 3'd2, 8'h00, 8'hA5},
        {2'd3, 3'd5, 8'h00, 8'h5A},
        {2'd3, 3'd1, 8'h00, 8'h11}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic proc_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); p_addr = a; p_wdata = d; p_wr = 1'b1;
        @(negedge clk); p_wr = 1'b0;
    endtask

    task automatic proc_read(input logic [2:0] a);
        @(negedge clk); p_addr = a; p_rd = 1'b1;
        @(negedge clk); p_rd = 1'b0;
    endtask

    task automatic proc_peek(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); p_addr = a; #1 d = p_rdata;
    endtask

    task automatic host_write(input logic [2:0] a, input logic [7:0] d, input logic use_cs);
        @(negedge clk); h_sel = a; h_data_in = d; h_cs_n = !use_cs;
        @(negedge clk); h_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        h_wr_n = 1'b1;
        repeat (5) @(negedge clk);
        h_cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic host_read(input logic [2:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk); h_sel = a; h_cs_n = 1'b0; h_rd_n = 1'b0;
        repeat (5) @(negedge clk);
        d = h_data_out; oe = h_data_oe;
        h_rd_n = 1'b1; h_cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic       oe;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 h_irq_n", {7'd0, h_irq_n}, 8'h01);
        chk("R1 p_irq", {7'd0, p_irq}, 8'h00);
        chk("R1 h_data_oe", {7'd0, h_data_oe}, 8'h00);
        for (int k = 0; k < 8; k++) begin
            proc_peek(3'(k), rd);
            chk("R1 register zero", rd, 8'h00);
        end

        // vector walk: R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            unique case (VEC[v][20:19])
                2'd0: proc_write(VEC[v][18:16], VEC[v][15:8]);
                2'd1: host_write(VEC[v][18:16], VEC[v][15:8], 1'b1);
                2'd2: begin
                    proc_peek(VEC[v][18:16], rd);
                    chk("R2 R3 R4 vector processor view", rd, VEC[v][7:0]);
                end
                default: begin
                    host_read(VEC[v][18:16], rd, oe);
                    chk("R5 vector host view", rd, VEC[v][7:0]);
                    chk("R5 vector oe", {7'd0, oe}, 8'h01);
                end
            endcase
        end

        // R5 oe needs both chip select and read
        @(negedge clk); h_cs_n = 1'b0; #1;
        chk("R5 oe cs only", {7'd0, h_data_oe}, 8'h00);
        h_cs_n = 1'b1; h_rd_n = 1'b0; #1;
        chk("R5 oe rd only", {7'd0, h_data_oe}, 8'h00);
        h_rd_n = 1'b1;

        // R10 write strobe without chip select
        host_write(3'd6, 8'h00, 1'b0);
        proc_peek(3'd6, rd);
        chk("R10 no cs write ignored", rd, 8'hC3);

        // R8 enables clear: no interrupts
        proc_write(3'd3, 8'h44);
        chk("R8 host irq stays off", {7'd0, h_irq_n}, 8'h01);
        host_write(3'd7, 8'h21, 1'b1);
        chk("R8 proc irq stays off", {7'd0, p_irq}, 8'h00);

        // R2 control keeps only bits 1:0
        proc_write(3'd0, 8'hFE);
        proc_peek(3'd0, rd);
        chk("R2 control mask", rd, 8'h02);

        // R6 host interrupt raise and release
        proc_write(3'd0, 8'h03);
        proc_write(3'd3, 8'h42);
        chk("R6 host irq raised", {7'd0, h_irq_n}, 8'h00);
        proc_peek(3'd0, rd);
        chk("R9 host flag bit4", rd, 8'h13);
        host_read(3'd3, rd, oe);
        chk("R6 host reads reg3", rd, 8'h42);
        chk("R6 host irq released", {7'd0, h_irq_n}, 8'h01);

        // R7 processor interrupt raise and release
        host_write(3'd7, 8'h5E, 1'b1);
        chk("R7 proc irq raised", {7'd0, p_irq}, 8'h01);
        proc_peek(3'd0, rd);
        chk("R9 proc flag bit5", rd, 8'h23);
        proc_read(3'd7);
        chk("R7 proc irq released", {7'd0, p_irq}, 8'h00);
        proc_peek(3'd7, rd);
        chk("R3 reg7 data", rd, 8'h5E);

        // R8 clearing an enable drops a pending interrupt
        host_write(3'd7, 8'h60, 1'b1);
        chk("R7 proc irq raised again", {7'd0, p_irq}, 8'h01);
        proc_write(3'd0, 8'h01);
        chk("R8 proc irq dropped", {7'd0, p_irq}, 8'h00);
        proc_peek(3'd0, rd);
        chk("R8 control after clear", rd, 8'h01);
        proc_write(3'd3, 8'h50);
        proc_write(3'd0, 8'h00);
        chk("R8 host irq dropped", {7'd0, h_irq_n}, 8'h01);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule